// File: doc/BRIEF.md
# Effective Address Sequencer

This unit works out the 16-bit memory address that an 8-bit processor's instruction operand refers to. Once per request it captures a four-bit addressing-mode code, up to two operand bytes, the X and Y index registers and the program counter. It then returns the final address together with a one-cycle valid strobe. Modes that name the target directly produce the address in the cycle after acceptance. The three pointer modes first read a two-byte little-endian pointer through a byte-wide read port with a combinational response. One of them adds X before the pointer fetch, another adds Y after it, and the third uses the full operand as the pointer location.

The controller has four states. IDLE waits for a request. FETCH_LO reads the pointer's low byte. FETCH_HI reads its high byte. DONE presents the address. The transitions are:
- IDLE->DONE: a direct mode is accepted.
- IDLE->FETCH_LO: a pointer mode is accepted.
- FETCH_LO->FETCH_HI: always.
- FETCH_HI->DONE: always.
- DONE->IDLE: always.

A request with an unassigned code leaves the unit in IDLE.

Top module: `ea_sequencer`

## Requirements
- R1: During and directly after reset, ea_valid and rd_req are low and ea and rd_addr read zero.
- R2: A request is accepted only when start is high and the unit is idle. The inputs are captured at acceptance. A start pulse while a request is in progress has no effect on its reads, its result or the number of valid strobes.
- R3: Mode 0 (immediate) returns pc, mode 1 (page zero) returns {8'h00, opnd_lo}, mode 2 (absolute) returns {opnd_hi, opnd_lo}. Each of these, like every mode from 0 to 5, raises ea_valid in the cycle after acceptance.
- R4: Mode 3 returns {opnd_hi, opnd_lo} + idx_x and mode 4 returns {opnd_hi, opnd_lo} + idx_y, with the index unsigned and the sum taken modulo 2^16.
- R5: Mode 5 (relative) returns pc plus opnd_lo read as a signed 8-bit value, modulo 2^16.
- R6: Mode 6 (absolute pointer) reads the low byte at {opnd_hi, opnd_lo} and the high byte at that address + 1, carrying into the upper byte, and returns {high, low}.
- R7: Mode 7 (pointer then Y) reads at {8'h00, opnd_lo} and {8'h00, opnd_lo+1 mod 256}, and returns {high, low} + idx_y modulo 2^16.
- R8: Mode 8 (X then pointer) forms z = (opnd_lo + idx_x) mod 256, reads at {8'h00, z} and {8'h00, z+1 mod 256}, and returns {high, low}.
- R9: In modes 6 to 8, rd_req is high in the two cycles after acceptance, low byte first, and ea_valid follows in the next cycle. ea_valid lasts exactly one cycle and is never high together with rd_req.
- R10: A start with mode code 9 to 15 is not accepted: no read and no valid strobe follow.
- R11: ea reads zero whenever ea_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code (0 to 8 assigned) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Program counter at the operand |
| rd_req | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte read address (zero when idle) |
| rd_data | input | 8 | Byte returned for rd_addr in the same cycle |
| ea_valid | output | 1 | Final address strobe, one cycle |
| ea | output | 16 | Final effective address |

## Verification
The hardest cases to reach from the ports are the pointer fetches that cross a boundary: a page-zero pointer at 0xFF must wrap to 0x00, an X-offset sum must wrap inside page zero, and an absolute pointer at xxFF must carry into the next page. The stimulus places operands on exactly those bytes. The bench memory is a computed function of the address, so the wrong wrap gives a different pointer and a different result. It also checks every read address in order. A second start pulse is driven while a pointer fetch is in flight, with a different mode and different operands, to show that the captured request is untouched.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] AM_IMM  = 4'd0;
    localparam logic [MODE_W-1:0] AM_ZP   = 4'd1;
    localparam logic [MODE_W-1:0] AM_ABS  = 4'd2;
    localparam logic [MODE_W-1:0] AM_ABSX = 4'd3;
    localparam logic [MODE_W-1:0] AM_ABSY = 4'd4;
    localparam logic [MODE_W-1:0] AM_REL  = 4'd5;
    localparam logic [MODE_W-1:0] AM_IND  = 4'd6;
    localparam logic [MODE_W-1:0] AM_INDY = 4'd7;
    localparam logic [MODE_W-1:0] AM_XIND = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2,
        ST_DONE     = 2'd3
    } seq_state_e;

    function automatic logic am_known(input logic [MODE_W-1:0] m);
        return m <= AM_XIND;
    endfunction

    function automatic logic am_pointer(input logic [MODE_W-1:0] m);
        return (m == AM_IND) || (m == AM_INDY) || (m == AM_XIND);
    endfunction

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic [DW-1:0]     op_lo,
    input  logic [DW-1:0]     op_hi,
    input  logic [DW-1:0]     ix,
    input  logic [DW-1:0]     iy,
    input  logic [AW-1:0]     pc_q,
    input  logic [DW-1:0]     ptr_lo,
    input  logic [DW-1:0]     ptr_hi,
    output logic [AW-1:0]     fetch_lo_addr,
    output logic [AW-1:0]     fetch_hi_addr,
    output logic [AW-1:0]     ea_calc
);
    localparam int PAD = AW - DW;

    logic [DW-1:0] zp_plus_x;
    logic [DW-1:0] zp_next;
    logic [DW-1:0] zpx_next;
    logic [AW-1:0] abs_addr;
    logic [AW-1:0] ptr_word;
    logic [AW-1:0] rel_off;

    assign zp_plus_x = op_lo + ix;
    assign zp_next   = op_lo + DW'(1);
    assign zpx_next  = zp_plus_x + DW'(1);
    assign abs_addr  = {op_hi, op_lo};
    assign ptr_word  = {ptr_hi, ptr_lo};
    assign rel_off   = {{PAD{op_lo[DW-1]}}, op_lo};

    always_comb begin
        fetch_lo_addr = '0;
        fetch_hi_addr = '0;
        case (mode_q)
            AM_IND: begin
                fetch_lo_addr = abs_addr;
                fetch_hi_addr = abs_addr + AW'(1);
            end
            AM_INDY: begin
                fetch_lo_addr = {{PAD{1'b0}}, op_lo};
                fetch_hi_addr = {{PAD{1'b0}}, zp_next};
            end
            AM_XIND: begin
                fetch_lo_addr = {{PAD{1'b0}}, zp_plus_x};
                fetch_hi_addr = {{PAD{1'b0}}, zpx_next};
            end
            default: ;
        endcase
    end

    always_comb begin
        case (mode_q)
            AM_IMM:  ea_calc = pc_q;
            AM_ZP:   ea_calc = {{PAD{1'b0}}, op_lo};
            AM_ABS:  ea_calc = abs_addr;
            AM_ABSX: ea_calc = abs_addr + {{PAD{1'b0}}, ix};
            AM_ABSY: ea_calc = abs_addr + {{PAD{1'b0}}, iy};
            AM_REL:  ea_calc = pc_q + rel_off;
            AM_IND:  ea_calc = ptr_word;
            AM_INDY: ea_calc = ptr_word + {{PAD{1'b0}}, iy};
            AM_XIND: ea_calc = ptr_word;
            default: ea_calc = '0;
        endcase
    end

endmodule

// File: rtl/ea_seq_ctrl.sv
module ea_seq_ctrl
    import ea_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    output logic              accept,
    output logic              rd_req,
    output logic              lo_phase,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              ea_valid
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start && am_known(mode))
                    state_nx = am_pointer(mode) ? ST_FETCH_LO : ST_DONE;
            end
            ST_FETCH_LO: state_nx = ST_FETCH_HI;
            ST_FETCH_HI: state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        rd_req   = 1'b0;
        lo_phase = 1'b0;
        ld_lo    = 1'b0;
        ld_hi    = 1'b0;
        ea_valid = 1'b0;
        unique case (state)
            ST_IDLE:     accept = start && am_known(mode);
            ST_FETCH_LO: begin
                rd_req   = 1'b1;
                lo_phase = 1'b1;
                ld_lo    = 1'b1;
            end
            ST_FETCH_HI: begin
                rd_req = 1'b1;
                ld_hi  = 1'b1;
            end
            ST_DONE:     ea_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_seq_capture.sv
module ea_seq_capture
    import ea_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    input  logic [AW-1:0]     pc,
    input  logic [DW-1:0]     rd_data,
    output logic [MODE_W-1:0] mode_q,
    output logic [DW-1:0]     op_lo_q,
    output logic [DW-1:0]     op_hi_q,
    output logic [DW-1:0]     x_q,
    output logic [DW-1:0]     y_q,
    output logic [AW-1:0]     pc_q,
    output logic [DW-1:0]     ptr_lo_q,
    output logic [DW-1:0]     ptr_hi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            op_lo_q <= '0;
            op_hi_q <= '0;
            x_q     <= '0;
            y_q     <= '0;
            pc_q    <= '0;
        end else if (accept) begin
            mode_q  <= mode;
            op_lo_q <= opnd_lo;
            op_hi_q <= opnd_hi;
            x_q     <= idx_x;
            y_q     <= idx_y;
            pc_q    <= pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
        end else begin
            if (ld_lo) ptr_lo_q <= rd_data;
            if (ld_hi) ptr_hi_q <= rd_data;
        end
    end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    input  logic [AW-1:0]     pc,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              ea_valid,
    output logic [AW-1:0]     ea
);
    logic              accept, lo_phase, ld_lo, ld_hi;
    logic [MODE_W-1:0] mode_q;
    logic [DW-1:0]     op_lo_q, op_hi_q, x_q, y_q, ptr_lo_q, ptr_hi_q;
    logic [AW-1:0]     pc_q, fetch_lo_addr, fetch_hi_addr, ea_calc;

    ea_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .accept   (accept),
        .rd_req   (rd_req),
        .lo_phase (lo_phase),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ea_valid (ea_valid)
    );

    ea_seq_capture #(.AW(AW), .DW(DW)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .mode     (mode),
        .opnd_lo  (opnd_lo),
        .opnd_hi  (opnd_hi),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .pc       (pc),
        .rd_data  (rd_data),
        .mode_q   (mode_q),
        .op_lo_q  (op_lo_q),
        .op_hi_q  (op_hi_q),
        .x_q      (x_q),
        .y_q      (y_q),
        .pc_q     (pc_q),
        .ptr_lo_q (ptr_lo_q),
        .ptr_hi_q (ptr_hi_q)
    );

    ea_addr_calc #(.AW(AW), .DW(DW)) i_calc (
        .mode_q        (mode_q),
        .op_lo         (op_lo_q),
        .op_hi         (op_hi_q),
        .ix            (x_q),
        .iy            (y_q),
        .pc_q          (pc_q),
        .ptr_lo        (ptr_lo_q),
        .ptr_hi        (ptr_hi_q),
        .fetch_lo_addr (fetch_lo_addr),
        .fetch_hi_addr (fetch_hi_addr),
        .ea_calc       (ea_calc)
    );

    assign rd_addr = !rd_req ? '0 : (lo_phase ? fetch_lo_addr : fetch_hi_addr);
    assign ea      = ea_valid ? ea_calc : '0;

endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk
    import ea_seq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic [MODE_W-1:0] mode,
    input logic              rd_req,
    input logic              ea_valid,
    input logic [AW-1:0]     ea
);
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);

    // R9
    rd_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && ea_valid));

    // R3
    direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !am_pointer(mode)) |=> (ea_valid && !rd_req));

    // R9
    pointer_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && am_pointer(mode)) |=> rd_req ##1 rd_req ##1 ea_valid);

    // R10
    known_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> am_known(mode));

    // R11
    ea_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_valid |-> (ea == '0));

endmodule

bind ea_sequencer ea_seq_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .mode     (mode),
    .rd_req   (rd_req),
    .ea_valid (ea_valid),
    .ea       (ea)
);

// File: tb/test_ea_sequencer.sv
`timescale 1ns/1ps
module test_ea_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
    logic [15:0] pc = '0;
    logic        rd_req, ea_valid;
    logic [15:0] rd_addr, ea;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int valid_cnt = 0;
    int read_cnt = 0;

    logic [15:0] q_ea[$];
    int          q_lat[$];
    int          q_start[$];
    string       q_tag[$];
    logic [15:0] q_rd[$];
    string       q_rdtag[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign rd_data = memf(rd_addr);

    ea_sequencer i_ea_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .pc(pc), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .ea_valid(ea_valid), .ea(ea)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL R9 watchdog: cycle %0d expected below %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // monitor: pops expected reads and results as the design produces them
    always @(negedge clk) begin
        if (rst_n && rd_req) begin
            read_cnt++;
            if (q_rd.size() == 0) begin
                check(1'b0, "R10", "unexpected read", {16'h0, rd_addr}, 32'h0);
            end else begin
                logic [15:0] ea_exp;
                string t;
                ea_exp = q_rd.pop_front();
                t = q_rdtag.pop_front();
                check(rd_addr == ea_exp, t, "read address", {16'h0, rd_addr}, {16'h0, ea_exp});
            end
        end
        if (rst_n && ea_valid) begin
            valid_cnt++;
            if (q_ea.size() == 0) begin
                check(1'b0, "R2", "unexpected valid", {16'h0, ea}, 32'h0);
            end else begin
                logic [15:0] e;
                int l, s;
                string t;
                e = q_ea.pop_front();
                l = q_lat.pop_front();
                s = q_start.pop_front();
                t = q_tag.pop_front();
                check(ea == e, t, "effective address", {16'h0, ea}, {16'h0, e});
                check(cyc - s == l, "R9", "latency", cyc - s, l);
            end
        end
    end

    task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                         input string tag, input bit poke);
        logic [15:0] e, a0, a1;
        logic [7:0]  z, z1;
        int lat, target;
        a0 = 16'h0;
        a1 = 16'h0;
        lat = 1;
        case (m)
            4'd0: e = p;
            4'd1: e = {8'h00, lo};
            4'd2: e = {hi, lo};
            4'd3: e = {hi, lo} + {8'h00, x};
            4'd4: e = {hi, lo} + {8'h00, y};
            4'd5: e = p + {{8{lo[7]}}, lo};
            4'd6: begin a0 = {hi, lo}; a1 = a0 + 16'd1; lat = 3; end
            4'd7: begin z1 = lo + 8'd1; a0 = {8'h00, lo}; a1 = {8'h00, z1}; lat = 3; end
            default: begin z = lo + x; z1 = z + 8'd1; a0 = {8'h00, z}; a1 = {8'h00, z1}; lat = 3; end
        endcase
        if (lat == 3) begin
            e = {memf(a1), memf(a0)};
            if (m == 4'd7) e = e + {8'h00, y};
            q_rd.push_back(a0); q_rdtag.push_back(tag);
            q_rd.push_back(a1); q_rdtag.push_back(tag);
        end
        target = valid_cnt + 1;
        @(negedge clk);
        mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p;
        start = 1'b1;
        q_ea.push_back(e); q_lat.push_back(lat); q_start.push_back(cyc); q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R2: second request while busy, different everything
            mode = 4'd2; opnd_lo = ~lo; opnd_hi = ~hi; idx_x = ~x; idx_y = ~y; pc = ~p;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (valid_cnt < target) @(negedge clk);
        @(negedge clk);
        // R11: address output quiet once the strobe has gone
        check(!ea_valid && ea == 16'h0, "R11", "ea when not valid", {16'h0, ea}, 32'h0);
        if (poke)
            check(valid_cnt == target, "R2", "valid count after busy start", valid_cnt, target);
    endtask

    task automatic issue_bad(input logic [3:0] m);
        int v0, r0;
        v0 = valid_cnt;
        r0 = read_cnt;
        @(negedge clk);
        mode = m; opnd_lo = 8'h10; opnd_hi = 8'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(valid_cnt == v0, "R10", "valid after unknown mode", valid_cnt, v0);
        check(read_cnt == r0, "R10", "reads after unknown mode", read_cnt, r0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!ea_valid && !rd_req, "R1", "strobes in reset", {30'h0, ea_valid, rd_req}, 32'h0);
        check(ea == 16'h0 && rd_addr == 16'h0, "R1", "buses in reset", {ea, rd_addr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ea_valid && !rd_req && ea == 16'h0, "R1", "after reset", {15'h0, ea_valid, ea}, 32'h0);

        issue(4'd0, 8'h77, 8'h66, 8'h01, 8'h02, 16'h1234, "R3", 1'b0);
        issue(4'd1, 8'h42, 8'h99, 8'h00, 8'h00, 16'hABCD, "R3", 1'b0);
        issue(4'd2, 8'h03, 8'h24, 8'h11, 8'h22, 16'h0000, "R3", 1'b0);
        issue(4'd3, 8'hFF, 8'h20, 8'h01, 8'h00, 16'h0000, "R4", 1'b0);
        issue(4'd3, 8'hFF, 8'hFF, 8'h02, 8'h00, 16'h0000, "R4", 1'b0);
        issue(4'd4, 8'h00, 8'h10, 8'h00, 8'hFF, 16'h0000, "R4", 1'b0);
        issue(4'd5, 8'h10, 8'h00, 8'h00, 8'h00, 16'h1000, "R5", 1'b0);
        issue(4'd5, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1000, "R5", 1'b0);
        issue(4'd5, 8'h20, 8'h00, 8'h00, 8'h00, 16'hFFF0, "R5", 1'b0);
        issue(4'd6, 8'h00, 8'h20, 8'h00, 8'h00, 16'h0000, "R6", 1'b0);
        issue(4'd6, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0000, "R6", 1'b0);
        issue(4'd7, 8'h42, 8'h00, 8'h00, 8'h05, 16'h0000, "R7", 1'b0);
        issue(4'd7, 8'hFF, 8'h33, 8'h00, 8'hF0, 16'h0000, "R7", 1'b0);
        issue(4'd8, 8'h40, 8'h00, 8'h05, 8'h00, 16'h0000, "R8", 1'b0);
        issue(4'd8, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000, "R8", 1'b0);
        issue(4'd8, 8'h80, 8'h44, 8'h90, 8'h00, 16'h0000, "R8", 1'b0);
        issue(4'd7, 8'h90, 8'h00, 8'h00, 8'h81, 16'h0000, "R2", 1'b1);
        issue(4'd1, 8'h5A, 8'h00, 8'h00, 8'h00, 16'h0000, "R2", 1'b1);
        issue_bad(4'd9);
        issue_bad(4'd15);

        check(q_ea.size() == 0 && q_rd.size() == 0, "R9", "outstanding items",
              q_ea.size() + q_rd.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule